// File: doc/BRIEF.md
# Atomic Control Register Access Unit

This block holds a small bank of control and status registers and carries out every access to them as one indivisible read-modify-write. An access names a 12-bit register address and one of six operations: swap, bit-set or bit-clear, each taking its operand either from a source register value or from a 5-bit immediate. The unit returns the register's value from before the access so it can be written to a destination register. In the same clock cycle it writes the new value, when the operation calls for a write.

The bank has four scratch registers that software can read and write, and one free-running cycle counter that software can only read. A bit-set or bit-clear with an empty mask reads the register and leaves it untouched. An empty mask means source register index zero in register form, or an immediate of zero in immediate form. This allows a pure read of the counter. An attempt to write the counter, an address that maps to nothing, or an undefined operation code raises an illegal-access flag. In each of these cases the access changes no state.

The read result and the illegal flag are combinational from the current state and the access inputs. The write lands at the next rising clock edge. A following access therefore sees the result of the access before it, even when the two arrive in consecutive cycles.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation code 3'b001 (swap, register form) writes `src_val` into the addressed register and returns its previous value on `old_val`. Accesses in consecutive cycles each see the value left by the one before.
- R2: Operation code 3'b010 (set, register form) ORs `src_val` into the addressed register and returns its previous value.
- R3: Operation code 3'b011 (clear, register form) clears the bits of the addressed register that are 1 in `src_val` and returns its previous value.
- R4: Operation codes 3'b101, 3'b110 and 3'b111 behave as swap, set and clear respectively. They use `imm_val` zero-extended to 32 bits as the operand and ignore `src_val`.
- R5: Set or clear with `src_idx` equal to 0 (register form) or `imm_val` equal to 0 (immediate form) returns the previous value and leaves the register unchanged. Such an access to the counter is legal.
- R6: The counter at address 0xC00 resets to 0, increases by exactly one every clock cycle, and returns its current value on a legal read.
- R7: Any access that would write an address whose two top bits are 2'b11, including the counter at 0xC00, raises `illegal` with `old_val` equal to 0 and changes no register.
- R8: An address other than 0x7C0 to 0x7C3 (scratch 0 to 3) or 0xC00, or an operation code of 3'b000 or 3'b100, raises `illegal` with `old_val` equal to 0 and changes no register.
- R9: While `valid` is low, no register changes, `illegal` is 0 and `old_val` is 0.
- R10: Reset clears all four scratch registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | An access is presented this cycle |
| addr | input | 12 | Register address |
| op | input | 3 | Operation code |
| src_val | input | 32 | Source register value (operand in register forms) |
| imm_val | input | 5 | Immediate operand (immediate forms) |
| src_idx | input | 5 | Source register index; zero marks an empty mask |
| old_val | output | 32 | Value of the register before the access |
| illegal | output | 1 | Access refused; no state changed |

## Verification
On every cycle, the assertions check four things: a refused or idle access leaves the scratch bank untouched; a set ORs exactly the mask into the prior value; an immediate swap stores the zero-extended immediate; the counter steps by one. Only the bench's scenarios show the values the bank holds as seen from the ports. These include the sequences that thread one register through swap, set and clear, and read-back through empty-mask reads. They also include the exact refusal cases at the address and operation-code boundaries, the measured counter distance between two reads, and the result of two accesses in consecutive cycles.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    // Kind of modification selected by the low two bits of the operation code
    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_SWAP  = 2'b01,
        ACT_SET   = 2'b10,
        ACT_CLEAR = 2'b11
    } csr_act_e;

    localparam int ADDR_W = 12;
    localparam int IMM_W  = 5;
    localparam int RIDX_W = 5;
    localparam int OP_W   = 3;

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode #(
    parameter int                ADDR_W   = 12,
    parameter int                SCR_N    = 4,
    parameter int                IDX_W    = 2,
    parameter logic [ADDR_W-1:0] SCR_BASE = 12'h7C0,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'hC00
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              scr_hit,
    output logic [IDX_W-1:0]  scr_idx,
    output logic              cnt_hit,
    output logic              ro_space
);

    logic [SCR_N-1:0] match;

    // One comparator per scratch slot
    for (genvar k = 0; k < SCR_N; k++) begin : g_slot
        assign match[k] = (addr == SCR_BASE + ADDR_W'(k));
    end

    always_comb begin
        scr_hit = |match;
        scr_idx = '0;
        for (int k = 0; k < SCR_N; k++) begin
            if (match[k]) begin
                scr_idx = IDX_W'(k);
            end
        end
        cnt_hit  = (addr == CNT_ADDR);
        // Top two address bits set marks a read-only register
        ro_space = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
    end

endmodule

// File: rtl/csr_rmw_opunit.sv
module csr_rmw_opunit
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [XLEN-1:0]   src_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [RIDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]   cur_val,
    output logic [XLEN-1:0]   nxt_val,
    output logic              op_ok,
    output logic              wr_req
);

    localparam int PAD_W = XLEN - IMM_W;

    logic            use_imm;
    logic [XLEN-1:0] operand;
    logic            mask_empty;
    csr_act_e        act;

    always_comb begin
        use_imm    = op[OP_W-1];
        operand    = use_imm ? {{PAD_W{1'b0}}, imm_val} : src_val;
        mask_empty = use_imm ? (imm_val == '0) : (src_idx == '0);
        act        = csr_act_e'(op[1:0]);
        op_ok      = (act != ACT_NONE);

        nxt_val = cur_val;
        wr_req  = 1'b0;
        unique case (act)
            ACT_SWAP: begin
                nxt_val = operand;
                wr_req  = 1'b1;
            end
            ACT_SET: begin
                nxt_val = cur_val | operand;
                wr_req  = !mask_empty;
            end
            ACT_CLEAR: begin
                nxt_val = cur_val & ~operand;
                wr_req  = !mask_empty;
            end
            default: begin
                nxt_val = cur_val;
                wr_req  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csr_rmw_counter.sv
module csr_rmw_counter #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] count
);

    logic [XLEN-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + XLEN'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // R6: counter advances by exactly one per cycle
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + XLEN'(1)));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                SCR_N    = 4,
    parameter logic [ADDR_W-1:0] SCR_BASE = 12'h7C0,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'hC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OP_W-1:0]   op,
    input  logic [XLEN-1:0]   src_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [RIDX_W-1:0] src_idx,
    output logic [XLEN-1:0]   old_val,
    output logic              illegal
);

    localparam int IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;

    typedef struct packed {
        logic [SCR_N-1:0][XLEN-1:0] scr;
    } bank_t;

    bank_t st_d, st_q;

    logic              scr_hit, cnt_hit, ro_space;
    logic [IDX_W-1:0]  scr_idx;
    logic [XLEN-1:0]   count;
    logic [XLEN-1:0]   cur_val, nxt_val;
    logic              op_ok, wr_req, refuse, commit;

    csr_rmw_decode #(
        .ADDR_W   (ADDR_W),
        .SCR_N    (SCR_N),
        .IDX_W    (IDX_W),
        .SCR_BASE (SCR_BASE),
        .CNT_ADDR (CNT_ADDR)
    ) decode_i (
        .addr     (addr),
        .scr_hit  (scr_hit),
        .scr_idx  (scr_idx),
        .cnt_hit  (cnt_hit),
        .ro_space (ro_space)
    );

    csr_rmw_counter #(.XLEN(XLEN)) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    csr_rmw_opunit #(.XLEN(XLEN)) opunit_i (
        .op      (op),
        .src_val (src_val),
        .imm_val (imm_val),
        .src_idx (src_idx),
        .cur_val (cur_val),
        .nxt_val (nxt_val),
        .op_ok   (op_ok),
        .wr_req  (wr_req)
    );

    // Read side and legality, all from current state
    always_comb begin
        if (cnt_hit) begin
            cur_val = count;
        end else if (scr_hit) begin
            cur_val = st_q.scr[scr_idx];
        end else begin
            cur_val = '0;
        end
        refuse  = !op_ok || !(scr_hit || cnt_hit) || (wr_req && (cnt_hit || ro_space));
        commit  = valid && !refuse;
        illegal = valid && refuse;
        old_val = commit ? cur_val : '0;
    end

    // Next state of the scratch bank
    always_comb begin
        st_d = st_q;
        if (commit && wr_req && scr_hit) begin
            st_d.scr[scr_idx] = nxt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: idle cycles leave the bank and outputs quiet
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!illegal && old_val == '0));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (st_q == $past(st_q)));

    // R7/R8: refused access changes nothing
    assert_refused_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && illegal) |=> (st_q == $past(st_q)));

    // R5: empty immediate mask on set/clear writes nothing
    assert_empty_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op[2] && op[1] && imm_val == '0) |=> (st_q == $past(st_q)));

    // R2: register-form set ORs the mask into the prior value
    assert_set_merges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !illegal && scr_hit && op == 3'b010 && src_idx != '0)
        |=> (st_q.scr[$past(scr_idx)] == ($past(old_val) | $past(src_val))));

    // R4: immediate swap stores the zero-extended immediate
    assert_imm_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !illegal && scr_hit && op == 3'b101)
        |=> (st_q.scr[$past(scr_idx)] == XLEN'($past(imm_val))));

endmodule

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_SWAP_R = 3'b001;
    localparam logic [2:0] OP_SET_R  = 3'b010;
    localparam logic [2:0] OP_CLR_R  = 3'b011;
    localparam logic [2:0] OP_SWAP_I = 3'b101;
    localparam logic [2:0] OP_SET_I  = 3'b110;
    localparam logic [2:0] OP_CLR_I  = 3'b111;
    localparam logic [11:0] A_S0  = 12'h7C0;
    localparam logic [11:0] A_S1  = 12'h7C1;
    localparam logic [11:0] A_S2  = 12'h7C2;
    localparam logic [11:0] A_S3  = 12'h7C3;
    localparam logic [11:0] A_CNT = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [11:0] addr = '0;
    logic [2:0]  op = '0;
    logic [31:0] src_val = '0;
    logic [4:0]  imm_val = '0;
    logic [4:0]  src_idx = '0;
    logic [31:0] old_val;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_rmw_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid),
        .addr    (addr),
        .op      (op),
        .src_val (src_val),
        .imm_val (imm_val),
        .src_idx (src_idx),
        .old_val (old_val),
        .illegal (illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample 1 time unit later, drop valid next falling edge
    task automatic access(input logic [11:0] a, input logic [2:0] o, input logic [31:0] v,
                          input logic [4:0] z, input logic [4:0] ri,
                          output logic [31:0] rd, output logic ill);
        @(negedge clk);
        valid = 1'b1; addr = a; op = o; src_val = v; imm_val = z; src_idx = ri;
        #1;
        rd = old_val; ill = illegal;
        @(negedge clk);
        valid = 1'b0;
    endtask

    // Empty-mask immediate set: pure read
    task automatic peek(input logic [11:0] a, output logic [31:0] rd);
        logic ill;
        access(a, OP_SET_I, 32'hFFFF_FFFF, 5'd0, 5'd0, rd, ill);
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        chk("R9 illegal idle after reset", {31'd0, illegal}, 32'd0);
        peek(A_S0, rd); chk("R10 scratch0 reset", rd, 32'd0);
        peek(A_S1, rd); chk("R10 scratch1 reset", rd, 32'd0);
        peek(A_S2, rd); chk("R10 scratch2 reset", rd, 32'd0);
        peek(A_S3, rd); chk("R10 scratch3 reset", rd, 32'd0);
    endtask

    task automatic t_reg_forms();
        logic [31:0] rd; logic ill;
        access(A_S0, OP_SWAP_R, 32'hDEAD_BEEF, 5'd0, 5'd7, rd, ill);
        chk("R1 swap returns old", rd, 32'd0);
        chk("R1 swap legal", {31'd0, ill}, 32'd0);
        peek(A_S0, rd); chk("R1 swap stored", rd, 32'hDEAD_BEEF);
        access(A_S1, OP_SWAP_R, 32'h0000_00F0, 5'd0, 5'd3, rd, ill);
        access(A_S1, OP_SET_R, 32'h0000_0F0F, 5'd0, 5'd4, rd, ill);
        chk("R2 set returns old", rd, 32'h0000_00F0);
        peek(A_S1, rd); chk("R2 set result", rd, 32'h0000_0FFF);
        access(A_S1, OP_CLR_R, 32'h0000_00FF, 5'd0, 5'd4, rd, ill);
        chk("R3 clear returns old", rd, 32'h0000_0FFF);
        peek(A_S1, rd); chk("R3 clear result", rd, 32'h0000_0F00);
    endtask

    task automatic t_imm_forms();
        logic [31:0] rd; logic ill;
        access(A_S2, OP_SWAP_I, 32'hFFFF_FFFF, 5'h15, 5'd9, rd, ill);
        chk("R4 imm swap returns old", rd, 32'd0);
        peek(A_S2, rd); chk("R4 imm swap zero-extended", rd, 32'h0000_0015);
        access(A_S2, OP_SET_I, 32'hFFFF_0000, 5'h0A, 5'd0, rd, ill);
        peek(A_S2, rd); chk("R4 imm set", rd, 32'h0000_001F);
        access(A_S2, OP_CLR_I, 32'h0000_00FF, 5'h03, 5'd0, rd, ill);
        chk("R4 imm clear returns old", rd, 32'h0000_001F);
        peek(A_S2, rd); chk("R4 imm clear", rd, 32'h0000_001C);
    endtask

    task automatic t_empty_mask();
        logic [31:0] rd; logic ill;
        access(A_S2, OP_SET_R, 32'hFFFF_FFFF, 5'd0, 5'd0, rd, ill);
        chk("R5 set x0 returns old", rd, 32'h0000_001C);
        peek(A_S2, rd); chk("R5 set x0 no write", rd, 32'h0000_001C);
        access(A_S2, OP_CLR_R, 32'hFFFF_FFFF, 5'd0, 5'd0, rd, ill);
        peek(A_S2, rd); chk("R5 clear x0 no write", rd, 32'h0000_001C);
        access(A_S2, OP_CLR_I, 32'hFFFF_FFFF, 5'd0, 5'd6, rd, ill);
        peek(A_S2, rd); chk("R5 clear imm0 no write", rd, 32'h0000_001C);
    endtask

    task automatic t_counter();
        logic [31:0] c1, c2;
        @(negedge clk);
        valid = 1'b1; addr = A_CNT; op = OP_SET_I; imm_val = 5'd0; src_idx = 5'd0; src_val = '0;
        #1;
        c1 = old_val;
        chk("R6 counter read legal", {31'd0, illegal}, 32'd0);
        chk("R6 counter nonzero after reset", {31'd0, (c1 != 0)}, 32'd1);
        repeat (7) @(negedge clk);
        #1;
        c2 = old_val;
        chk("R6 counter step over 7 cycles", c2 - c1, 32'd7);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic t_counter_write();
        logic [31:0] rd; logic ill;
        access(A_CNT, OP_SWAP_R, 32'h1234_5678, 5'd0, 5'd1, rd, ill);
        chk("R7 counter swap illegal", {31'd0, ill}, 32'd1);
        chk("R7 counter swap rd zero", rd, 32'd0);
        access(A_CNT, OP_SET_I, 32'd0, 5'd3, 5'd0, rd, ill);
        chk("R7 counter set imm illegal", {31'd0, ill}, 32'd1);
        access(12'hC01, OP_SWAP_I, 32'd0, 5'd1, 5'd0, rd, ill);
        chk("R7 read-only space write illegal", {31'd0, ill}, 32'd1);
        access(A_CNT, OP_SET_R, 32'h0000_00FF, 5'd0, 5'd0, rd, ill);
        chk("R5 counter set x0 legal", {31'd0, ill}, 32'd0);
    endtask

    task automatic t_bad_access();
        logic [31:0] rd; logic ill;
        access(12'h7C4, OP_SWAP_R, 32'h1234_5678, 5'd0, 5'd1, rd, ill);
        chk("R8 addr past bank illegal", {31'd0, ill}, 32'd1);
        access(12'h300, OP_SET_I, 32'd0, 5'd0, 5'd0, rd, ill);
        chk("R8 unmapped read illegal", {31'd0, ill}, 32'd1);
        access(A_S0, 3'b000, 32'h1234_5678, 5'd0, 5'd1, rd, ill);
        chk("R8 op 000 illegal", {31'd0, ill}, 32'd1);
        chk("R8 op 000 rd zero", rd, 32'd0);
        access(A_S0, 3'b100, 32'h1234_5678, 5'd1, 5'd1, rd, ill);
        chk("R8 op 100 illegal", {31'd0, ill}, 32'd1);
        peek(A_S0, rd); chk("R8 scratch0 untouched", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_back_to_back();
        logic [31:0] rd, r1, r2; logic ill;
        access(A_S3, OP_SWAP_R, 32'h0000_0100, 5'd0, 5'd2, rd, ill);
        @(negedge clk);
        valid = 1'b1; addr = A_S3; op = OP_SET_R; src_val = 32'h1; src_idx = 5'd5; imm_val = '0;
        #1; r1 = old_val;
        @(negedge clk);
        src_val = 32'h2;
        #1; r2 = old_val;
        @(negedge clk);
        valid = 1'b0;
        chk("R1 first of pair sees old", r1, 32'h0000_0100);
        chk("R1 second of pair sees first result", r2, 32'h0000_0101);
        peek(A_S3, rd); chk("R1 pair final", rd, 32'h0000_0103);
    endtask

    task automatic t_idle();
        logic [31:0] rd;
        @(negedge clk);
        valid = 1'b0; addr = A_S3; op = OP_SWAP_R; src_val = 32'hAAAA_AAAA; src_idx = 5'd1;
        #1;
        chk("R9 idle illegal low", {31'd0, illegal}, 32'd0);
        chk("R9 idle rd zero", old_val, 32'd0);
        repeat (2) @(negedge clk);
        peek(A_S3, rd); chk("R9 idle no write", rd, 32'h0000_0103);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg_forms();
        t_imm_forms();
        t_empty_mask();
        t_counter();
        t_counter_write();
        t_bad_access();
        t_back_to_back();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule